// File: doc/BRIEF.md
# Block-Serial Digest Engine Controller

The engine walks a message held in byte-wide RAM one 64-byte block at a time. For each block it streams the bytes in over a RAM master port and assembles them into a 512-bit word. It places that word above a 160-bit running digest, hands the 672-bit result to an external compression stage, and keeps the 160-bit answer as the new digest. Once the whole length has been consumed, it streams the 20 digest bytes out to a second RAM region.

Software sets up the engine through a byte-wide host port decoded inside a 16-byte window. Three 16-bit registers hold the source base, the destination base and the message length. A command byte launches a job, and a status byte exposes the sequencer phase. A step strobe paces the sequencer. The strobe is honoured in a fetch or store phase only after that phase's byte transfers have finished. The compression stage, message padding and initial hash constants are outside the block.

Top module: `hash_blk_engine`

## Requirements
- R1: After reset the status byte reads 0 (idle), all three 16-bit registers read 0, and neither `mem_re` nor `mem_we` is asserted.
- R2: The window offsets 2/3 hold the source base, 4/5 the destination base and 6/7 the length. Offset bit 0 selects the low byte (0) or the high byte (1). A written byte reads back unchanged.
- R3: `host_rdata` is 0x00 when `host_rd` is low, for offset 0, for offsets 8 to 15, and for any address outside the window.
- R4: Host writes to the source base, destination base and length are discarded while the status is not idle.
- R5: A host write to offset 0 with data bit 0 set, while idle, moves the status to fetch (1) and clears the byte count and the digest. With bit 0 clear, the write does nothing.
- R6: The status byte at offset 1 reads idle=0, fetch=1, compress=2 or store=3, and its upper six bits are always zero.
- R7: In fetch, 64 read requests go out on consecutive cycles to source base + byte count + i, for i = 0..63. Read data arrives on the cycle after the request. Byte i lands in bits [511-8i : 504-8i] of the block.
- R8: A step moves fetch to compress only after all 64 bytes have been received. It moves store to idle only after all 20 bytes have been written. In compress, every step is taken.
- R9: On a step in compress, the digest is replaced by `cf_out`. `cf_in` is always {block, digest}.
- R10: Leaving fetch adds 64 to the byte count. Leaving compress goes back to fetch if the count is below the length and to store otherwise, so a job always hashes at least one block.
- R11: In store, 20 write requests go out on consecutive cycles. Request i carries digest bits [8i+7:8i] to destination base + byte count + i.
- R12: `mem_re` is asserted only in fetch and `mem_we` only in store, never both together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| step | input | 1 | Sequencer advance strobe |
| mem_re | output | 1 | RAM read request |
| mem_we | output | 1 | RAM write request |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, valid one cycle after `mem_re` |
| cf_in | output | 672 | Compression input {block, digest} |
| cf_out | input | 160 | Compression result |

## Verification
The bench holds the step strobe low while a fetch or store is still in progress. A sequencer that jumped phase early would compress a partial block or truncate the stored digest, and the status readback catches it sitting in the wrong phase. Lengths of 0, exactly 64 and 150 check the loop-exit comparison. An off-by-one there would hash one block too many or too few, and the digest would land at a shifted destination address. Guard bytes on both sides of each destination run catch stores that go to the wrong offset. Running the same job twice catches a digest that is not cleared on start. A register write made mid-job must read back unchanged afterwards.

// File: rtl/hse_pkg.sv
`timescale 1ns/1ps
package hse_pkg;
  localparam int HSE_AW  = 16;
  localparam int HSE_WIN = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_OP    = 2'd2,
    ST_WRITE = 2'd3
  } hse_state_e;

  localparam logic [HSE_WIN-1:0] OFF_START = 4'd0;
  localparam logic [HSE_WIN-1:0] OFF_STATE = 4'd1;

  function automatic logic [HSE_AW-1:0] merge_byte(logic [HSE_AW-1:0] r, logic hi, logic [7:0] d);
    merge_byte = hi ? {d, r[7:0]} : {r[15:8], d};
  endfunction

  function automatic logic [7:0] pick_byte(logic [HSE_AW-1:0] r, logic hi);
    pick_byte = hi ? r[15:8] : r[7:0];
  endfunction
endpackage

// File: rtl/hse_hostregs.sv
`timescale 1ns/1ps
module hse_hostregs
  import hse_pkg::*;
#(
  parameter logic [HSE_AW-1:0] BASE_ADDR = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HSE_AW-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  input  hse_state_e        st,
  output logic [7:0]        host_rdata,
  output logic [HSE_AW-1:0] rd_base,
  output logic [HSE_AW-1:0] wr_base,
  output logic [HSE_AW-1:0] msg_len,
  output logic              start_evt
);
  logic              in_win;
  logic [HSE_WIN-1:0] off;
  logic              wr_ok;

  assign in_win    = host_addr[HSE_AW-1:HSE_WIN] == BASE_ADDR[HSE_AW-1:HSE_WIN];
  assign off       = host_addr[HSE_WIN-1:0];
  assign wr_ok     = host_wr && in_win && (st == ST_IDLE);
  assign start_evt = wr_ok && (off == OFF_START) && host_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_base <= '0;
      wr_base <= '0;
      msg_len <= '0;
    end else if (wr_ok) begin
      case (off[HSE_WIN-1:1])
        3'd1: rd_base <= merge_byte(rd_base, off[0], host_wdata);
        3'd2: wr_base <= merge_byte(wr_base, off[0], host_wdata);
        3'd3: msg_len <= merge_byte(msg_len, off[0], host_wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (host_rd && in_win) begin
      if (off == OFF_STATE) host_rdata = {6'b0, st};
      else begin
        case (off[HSE_WIN-1:1])
          3'd1: host_rdata = pick_byte(rd_base, off[0]);
          3'd2: host_rdata = pick_byte(wr_base, off[0]);
          3'd3: host_rdata = pick_byte(msg_len, off[0]);
          default: host_rdata = 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/hse_mover.sv
`timescale 1ns/1ps
module hse_mover
  import hse_pkg::*;
#(
  parameter int BLK_BYTES = 64,
  parameter int DIG_BYTES = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  hse_state_e             st,
  input  logic [HSE_AW-1:0]      rd_base,
  input  logic [HSE_AW-1:0]      wr_base,
  input  logic [HSE_AW-1:0]      bp,
  input  logic [DIG_BYTES*8-1:0] digest,
  input  logic [7:0]             mem_rdata,
  output logic                   mem_re,
  output logic                   mem_we,
  output logic [HSE_AW-1:0]      mem_addr,
  output logic [7:0]             mem_wdata,
  output logic [BLK_BYTES*8-1:0] block,
  output logic                   rd_done,
  output logic                   wr_done
);
  localparam int BLK_W = BLK_BYTES * 8;
  localparam int DIG_W = DIG_BYTES * 8;
  localparam int CW    = $clog2(BLK_BYTES + 1);

  logic [CW-1:0] xcnt, ccnt;
  logic          pend;
  logic          in_read, in_write;

  function automatic logic [BLK_W-1:0] put_byte(logic [BLK_W-1:0] b, logic [CW-1:0] i, logic [7:0] d);
    logic [BLK_W-1:0] r;
    r = b;
    r[BLK_W - 8 - 8 * int'(i) +: 8] = d;
    return r;
  endfunction

  function automatic logic [7:0] dig_byte(logic [DIG_W-1:0] dg, logic [CW-1:0] i);
    if (int'(i) < DIG_BYTES) return dg[8 * int'(i) +: 8];
    return 8'h00;
  endfunction

  assign in_read   = (st == ST_READ);
  assign in_write  = (st == ST_WRITE);
  assign mem_re    = in_read  && (xcnt < CW'(BLK_BYTES));
  assign mem_we    = in_write && (xcnt < CW'(DIG_BYTES));
  assign mem_addr  = (in_write ? wr_base : rd_base) + bp + HSE_AW'(xcnt);
  assign mem_wdata = dig_byte(digest, xcnt);
  assign rd_done   = in_read  && (ccnt == CW'(BLK_BYTES));
  assign wr_done   = in_write && (xcnt == CW'(DIG_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcnt  <= '0;
      ccnt  <= '0;
      pend  <= 1'b0;
      block <= '0;
    end else if (!(in_read || in_write)) begin
      xcnt <= '0;
      ccnt <= '0;
      pend <= 1'b0;
    end else begin
      if (mem_re || mem_we) xcnt <= xcnt + 1'b1;
      pend <= mem_re;
      if (pend) begin
        block <= put_byte(block, ccnt, mem_rdata);
        ccnt  <= ccnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hse_ctrl.sv
`timescale 1ns/1ps
module hse_ctrl
  import hse_pkg::*;
#(
  parameter int BLK_BYTES = 64,
  parameter int DIG_BYTES = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_evt,
  input  logic                   step,
  input  logic                   rd_done,
  input  logic                   wr_done,
  input  logic [HSE_AW-1:0]      msg_len,
  input  logic [DIG_BYTES*8-1:0] cf_out,
  output hse_state_e             st,
  output logic [HSE_AW-1:0]      bp,
  output logic [DIG_BYTES*8-1:0] digest
);
  function automatic logic [HSE_AW-1:0] bp_add(logic [HSE_AW-1:0] v);
    return v + HSE_AW'(BLK_BYTES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bp     <= '0;
      digest <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_evt) begin
          st     <= ST_READ;
          bp     <= '0;
          digest <= '0;
        end
        ST_READ: if (step && rd_done) begin
          st <= ST_OP;
          bp <= bp_add(bp);
        end
        ST_OP: if (step) begin
          digest <= cf_out;
          st     <= (bp < msg_len) ? ST_READ : ST_WRITE;
        end
        ST_WRITE: if (step && wr_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hash_blk_engine.sv
`timescale 1ns/1ps
module hash_blk_engine
  import hse_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'hFE00,
  parameter int BLK_BYTES = 64,
  parameter int DIG_BYTES = 20,
  localparam int BLK_W = BLK_BYTES * 8,
  localparam int DIG_W = DIG_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               step,
  output logic               mem_re,
  output logic               mem_we,
  output logic [15:0]        mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic [BLK_W+DIG_W-1:0] cf_in,
  input  logic [DIG_W-1:0]   cf_out
);
  hse_state_e        st;
  logic [HSE_AW-1:0] rd_base, wr_base, msg_len, bp;
  logic [DIG_W-1:0]  digest;
  logic [BLK_W-1:0]  block;
  logic              start_evt, rd_done, wr_done;

  assign cf_in = {block, digest};

  hse_hostregs #(.BASE_ADDR(BASE_ADDR)) u_regs (
    .clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata, .st,
    .host_rdata, .rd_base, .wr_base, .msg_len, .start_evt
  );

  hse_mover #(.BLK_BYTES(BLK_BYTES), .DIG_BYTES(DIG_BYTES)) u_mover (
    .clk, .rst_n, .st, .rd_base, .wr_base, .bp, .digest, .mem_rdata,
    .mem_re, .mem_we, .mem_addr, .mem_wdata, .block, .rd_done, .wr_done
  );

  hse_ctrl #(.BLK_BYTES(BLK_BYTES), .DIG_BYTES(DIG_BYTES)) u_ctrl (
    .clk, .rst_n, .start_evt, .step, .rd_done, .wr_done, .msg_len, .cf_out,
    .st, .bp, .digest
  );
endmodule

// File: rtl/hse_chk.sv
`timescale 1ns/1ps
module hse_chk
  import hse_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'hFE00,
  parameter int BLK_BYTES = 64,
  parameter int DIG_BYTES = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input hse_state_e             st,
  input logic [HSE_AW-1:0]      bp,
  input logic [HSE_AW-1:0]      msg_len,
  input logic [HSE_AW-1:0]      rd_base,
  input logic [HSE_AW-1:0]      wr_base,
  input logic [DIG_BYTES*8-1:0] digest,
  input logic [DIG_BYTES*8-1:0] cf_out,
  input logic                   start_evt,
  input logic                   rd_done,
  input logic                   wr_done,
  input logic                   step,
  input logic                   mem_re,
  input logic                   mem_we,
  input logic                   host_rd,
  input logic [15:0]            host_addr,
  input logic [7:0]             host_rdata
);
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == BASE_ADDR + 16'd1) |-> host_rdata[7:2] == 6'd0); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_READ && bp == '0 && digest == '0)); // R5
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && !(step && rd_done)) |=> st == ST_READ); // R8
  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRITE && !(step && wr_done)) |=> st == ST_WRITE); // R8
  AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && step && rd_done) |=> bp == $past(bp) + HSE_AW'(BLK_BYTES)); // R10
  AST_OP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OP && step && bp >= msg_len) |=> st == ST_WRITE); // R10
  AST_DIGEST_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OP && step) |=> digest == $past(cf_out)); // R9
  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> ($stable(msg_len) && $stable(rd_base) && $stable(wr_base))); // R4
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we)); // R12
  AST_RE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> st == ST_READ); // R12
  AST_WE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> st == ST_WRITE); // R12
endmodule

bind hash_blk_engine hse_chk #(
  .BASE_ADDR(BASE_ADDR), .BLK_BYTES(BLK_BYTES), .DIG_BYTES(DIG_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .bp(bp), .msg_len(msg_len),
  .rd_base(rd_base), .wr_base(wr_base), .digest(digest), .cf_out(cf_out),
  .start_evt(start_evt), .rd_done(rd_done), .wr_done(wr_done), .step(step),
  .mem_re(mem_re), .mem_we(mem_we), .host_rd(host_rd), .host_addr(host_addr),
  .host_rdata(host_rdata)
);

// File: tb/hash_blk_engine_tb.sv
`timescale 1ns/1ps
module hash_blk_engine_tb;
  localparam logic [15:0] BASE = 16'hFE00;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  host_addr = '0;
  logic         host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         step = 1'b0;
  logic         mem_re, mem_we;
  logic [15:0]  mem_addr;
  logic [7:0]   mem_wdata;
  logic [7:0]   mem_rdata = '0;
  logic [671:0] cf_in;
  logic [159:0] cf_out;

  int n_checks = 0, n_errors = 0;
  int n_re = 0, n_we = 0;
  logic [7:0] ram [0:1023];

  always #2.5 clk = ~clk;

  function automatic logic [159:0] stand_cf(logic [671:0] x);
    logic [511:0] b;
    logic [159:0] d;
    b = x[671:160];
    d = x[159:0];
    return {d[158:0], d[159]} ^ b[511:352] ^ b[159:0] ^ b[335:176];
  endfunction

  assign cf_out = stand_cf(cf_in);

  always @(posedge clk) begin
    if (mem_re) begin mem_rdata <= ram[mem_addr[9:0]]; n_re <= n_re + 1; end
    if (mem_we) begin ram[mem_addr[9:0]] <= mem_wdata; n_we <= n_we + 1; end
  end

  hash_blk_engine u_dut (
    .clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .step, .mem_re, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .cf_in, .cf_out
  );

  task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic set_regs(logic [15:0] rb, logic [15:0] wb, logic [15:0] ln);
    hwrite(BASE + 16'd2, rb[7:0]); hwrite(BASE + 16'd3, rb[15:8]);
    hwrite(BASE + 16'd4, wb[7:0]); hwrite(BASE + 16'd5, wb[15:8]);
    hwrite(BASE + 16'd6, ln[7:0]); hwrite(BASE + 16'd7, ln[15:8]);
  endtask

  // bench model: blocks MSB-first, digest starts at zero, do-while over length
  task automatic model(logic [15:0] rb, logic [15:0] ln,
                       output logic [159:0] d, output logic [15:0] fbp);
    logic [511:0] b;
    logic [15:0] p;
    d = '0; p = '0;
    do begin
      for (int i = 0; i < 64; i++) b[511 - 8*i -: 8] = ram[10'(rb + p + 16'(i))];
      d = stand_cf({b, d});
      p = p + 16'd64;
    end while (p < ln);
    fbp = p;
  endtask

  task automatic wait_idle(output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      hread(BASE + 16'd1, s);
      if (s == 8'd0) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_out(string req, logic [15:0] wb, logic [15:0] fbp, logic [159:0] exp);
    logic [159:0] got;
    for (int i = 0; i < 20; i++) got[8*i +: 8] = ram[10'(wb + fbp + 16'(i))];
    chk(req, got, exp);
    chk({req, " guard-low"},  160'(ram[10'(wb + fbp - 16'd1)]), 160'h5A);
    chk({req, " guard-high"}, 160'(ram[10'(wb + fbp + 16'd20)]), 160'h5A);
  endtask

  task automatic run_job(string req, logic [15:0] rb, logic [15:0] wb, logic [15:0] ln);
    logic [159:0] exp;
    logic [15:0] fbp;
    bit ok;
    model(rb, ln, exp, fbp);
    for (int i = -1; i <= 20; i++) ram[10'(wb + fbp + 16'(i))] = (i < 0 || i == 20) ? 8'h5A : 8'h00;
    set_regs(rb, wb, ln);
    step = 1'b1;
    n_re = 0; n_we = 0;
    hwrite(BASE, 8'h01);
    wait_idle(ok);
    chk({req, " finish"}, 160'(ok), 160'd1);
    check_out({req, " R9 R11 digest"}, wb, fbp, exp);
    chk({req, " R7 read count"},  160'(n_re), 160'(fbp));
    chk({req, " R11 write count"}, 160'(n_we), 160'd20);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 mem_re", 160'(mem_re), 0);
    chk("R1 mem_we", 160'(mem_we), 0);
    hread(BASE + 16'd1, d); chk("R1 status", 160'(d), 0);
    for (int o = 2; o < 8; o++) begin
      hread(BASE + 16'(o), d); chk("R1 regs zero", 160'(d), 0);
    end
  endtask

  task automatic t_regs;
    logic [7:0] d;
    set_regs(16'h1234, 16'hA5C3, 16'h0F81);
    hread(BASE + 16'd2, d); chk("R2 rd lo", 160'(d), 160'h34);
    hread(BASE + 16'd3, d); chk("R2 rd hi", 160'(d), 160'h12);
    hread(BASE + 16'd4, d); chk("R2 wr lo", 160'(d), 160'hC3);
    hread(BASE + 16'd5, d); chk("R2 wr hi", 160'(d), 160'hA5);
    hread(BASE + 16'd6, d); chk("R2 len lo", 160'(d), 160'h81);
    hread(BASE + 16'd7, d); chk("R2 len hi", 160'(d), 160'h0F);
    hread(BASE + 16'd0, d); chk("R3 start offset", 160'(d), 0);
    hread(BASE + 16'd9, d); chk("R3 offset 9", 160'(d), 0);
    hread(BASE + 16'd15, d); chk("R3 offset 15", 160'(d), 0);
    hread(16'hFE12, d); chk("R3 outside window", 160'(d), 0);
    @(negedge clk); host_addr = BASE + 16'd2; #1;
    chk("R3 no read strobe", 160'(host_rdata), 0);
  endtask

  task automatic t_nostart;
    logic [7:0] d;
    hwrite(BASE, 8'h02);
    repeat (3) @(negedge clk);
    hread(BASE + 16'd1, d); chk("R5 bit0 clear no start", 160'(d), 0);
    chk("R5 no fetch", 160'(mem_re), 0);
  endtask

  task automatic t_gated;
    logic [7:0] d;
    logic [159:0] exp;
    logic [15:0] fbp;
    bit ok;
    model(16'h0080, 16'd10, exp, fbp);
    for (int i = -1; i <= 20; i++) ram[10'(16'h0340 + fbp + 16'(i))] = (i < 0 || i == 20) ? 8'h5A : 8'h00;
    set_regs(16'h0080, 16'h0340, 16'd10);
    step = 1'b0;
    hwrite(BASE, 8'h01);
    hwrite(BASE + 16'd2, 8'hEE);
    repeat (80) @(negedge clk);
    hread(BASE + 16'd1, d); chk("R8 R6 held in fetch", 160'(d), 160'd1);
    @(negedge clk); step = 1'b1; @(negedge clk); step = 1'b0;
    hread(BASE + 16'd1, d); chk("R8 compress", 160'(d), 160'd2);
    @(negedge clk); step = 1'b1; @(negedge clk); step = 1'b0;
    hread(BASE + 16'd1, d); chk("R10 len 10 to store", 160'(d), 160'd3);
    repeat (30) @(negedge clk);
    hread(BASE + 16'd1, d); chk("R8 held in store", 160'(d), 160'd3);
    step = 1'b1;
    wait_idle(ok);
    chk("R8 store done", 160'(ok), 160'd1);
    check_out("R11 gated digest", 16'h0340, fbp, exp);
    hread(BASE + 16'd2, d); chk("R4 busy write ignored", 160'(d), 160'h80);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 8'((i * 37) ^ (i >> 3) ^ 8'h6B);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_nostart();
    run_job("R10 single block", 16'h0040, 16'h0200, 16'd64);
    run_job("R10 three blocks", 16'h0100, 16'h0300, 16'd150);
    run_job("R10 zero length", 16'h0000, 16'h0280, 16'd0);
    run_job("R5 restart clears digest", 16'h0040, 16'h0200, 16'd64);
    t_gated();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #750000;
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule